// File: doc/BRIEF.md
# Multi-plane pixel colour comparator

This block checks a byte-wide strip of eight pixels against a small bank of reference colours. On a start strobe it fetches the blue, red, green and (when fitted) fourth plane bytes stored at one address. It rebuilds a 4-bit colour code for each pixel from the same bit position of every plane byte. It then reports, in an 8-bit status byte, which pixels match at least one of eight programmable compare entries. A raster unit elsewhere uses that status to gate its writes.

The compare runs when a command arrives whose operation field is 7, or whose pre-compare bit is set. Planes that are switched off are removed from both sides of every equality test. Each compare entry carries its own disable bit. The status register can only be read, and it changes in a single step once every plane byte has arrived.

Top module: `plane_color_match`

## Requirements
- R1: After reset the status output is 0x00 and all eight compare entries hold 0x80, so a compare made before any entry write reports 0x00.
- R2: A `go` strobe starts a compare only when `cmd[2:0]` equals 7, or when `cmd[6]` is 1 and `cmd[2:0]` is not 7. Any other command makes no plane read, raises no `done` and leaves the status unchanged.
- R3: A compare issues exactly one read per present plane, in plane order 0 (blue), 1 (red), 2 (green), 3 (fourth). All reads use the address given with `go`. Plane 3 is read only when `has_plane3` is 1. Read data is taken one cycle after its request.
- R4: The colour code of pixel i is {plane3[i], green[i], red[i], blue[i]}, with blue in bit 0. Plane byte bit 7 is the leftmost pixel, and pixel i drives status bit i.
- R5: An entry whose bit 7 is 1 never produces a match.
- R6: The compare mask is the 4-bit inverse of `plane_off`, with bit 3 also cleared when `has_plane3` is 0. Both the pixel code and entry bits [3:0] are ANDed with this mask before the equality test.
- R7: A status bit is 1 exactly when the masked pixel code equals the masked low nibble of at least one enabled entry.
- R8: The status changes only in the cycle in which `done` is high. `done` is a single-cycle pulse that carries the new status.
- R9: A `go` that arrives while `busy` is high is ignored.
- R10: A write with `ent_we` high stores `ent_data` into the entry selected by `ent_idx`. That value is used by every later compare.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ent_we | input | 1 | Compare entry write enable |
| ent_idx | input | 3 | Compare entry select |
| ent_data | input | 8 | Entry value; bit 7 disables the entry, bits [3:0] hold the colour |
| plane_off | input | 4 | Planes switched off, one bit per plane |
| has_plane3 | input | 1 | Fourth plane present |
| go | input | 1 | Command strobe |
| cmd | input | 8 | Command byte; bit 6 requests a pre-compare, bits [2:0] hold the operation |
| addr | input | ADDR_W | Byte address to compare |
| mem_rd_en | output | 1 | Plane read request |
| mem_rd_plane | output | 2 | Plane being read |
| mem_rd_addr | output | ADDR_W | Read address |
| mem_rd_data | input | 8 | Plane byte, returned one cycle after the request |
| busy | output | 1 | Compare in progress |
| done | output | 1 | One-cycle pulse when the status updates |
| status | output | 8 | Match status, one bit per pixel |

## Verification
The assertions assume a memory that always answers one cycle after a request. They also assume `plane_off` and `has_plane3` are sampled only when a command is accepted. The bench models memory with exactly that fixed latency and changes plane data, mask inputs and entries only between compares. The `go` pulses sent while busy are there to probe R9, and the assertions also hold for those.

// File: rtl/plane_color_match.sv
module plane_color_match #(
  parameter int ADDR_W = 15,
  parameter int NENT   = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ent_we,
  input  logic [$clog2(NENT)-1:0] ent_idx,
  input  logic [7:0]              ent_data,
  input  logic [3:0]              plane_off,
  input  logic                    has_plane3,
  input  logic                    go,
  input  logic [7:0]              cmd,
  input  logic [ADDR_W-1:0]       addr,
  output logic                    mem_rd_en,
  output logic [1:0]              mem_rd_plane,
  output logic [ADDR_W-1:0]       mem_rd_addr,
  input  logic [7:0]              mem_rd_data,
  output logic                    busy,
  output logic                    done,
  output logic [7:0]              status
);
  localparam int PIX = 8;

  logic [7:0]        ent_q [NENT];
  logic [7:0]        pb [4];
  logic [3:0]        cmask_q;
  logic              has4_q;
  logic [1:0]        rd_idx;
  logic              rd_on;
  logic              pend_v;
  logic [1:0]        pend_idx;
  logic              eval;
  logic [ADDR_W-1:0] addr_q;
  logic [PIX-1:0]    hit;

  wire       trig     = (cmd[2:0] == 3'd7) || cmd[6];
  wire       accept   = go && !busy && trig;
  wire [1:0] last_idx = has4_q ? 2'd3 : 2'd2;

  assign mem_rd_en    = rd_on;
  assign mem_rd_plane = rd_idx;
  assign mem_rd_addr  = addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NENT; i++) ent_q[i] <= 8'h80;
    end else if (ent_we) begin
      ent_q[ent_idx] <= ent_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      rd_on    <= 1'b0;
      rd_idx   <= 2'd0;
      pend_v   <= 1'b0;
      pend_idx <= 2'd0;
      eval     <= 1'b0;
      done     <= 1'b0;
      status   <= 8'h00;
      cmask_q  <= 4'h0;
      has4_q   <= 1'b0;
      addr_q   <= '0;
      for (int p = 0; p < 4; p++) pb[p] <= 8'h00;
    end else begin
      done     <= 1'b0;
      pend_v   <= rd_on;
      pend_idx <= rd_idx;
      if (accept) begin
        busy    <= 1'b1;
        rd_on   <= 1'b1;
        rd_idx  <= 2'd0;
        addr_q  <= addr;
        has4_q  <= has_plane3;
        cmask_q <= ~plane_off & {has_plane3, 3'b111};
      end else if (rd_on) begin
        if (rd_idx == last_idx) rd_on <= 1'b0;
        else                    rd_idx <= rd_idx + 2'd1;
      end
      if (pend_v) begin
        pb[pend_idx] <= mem_rd_data;
        if (pend_idx == last_idx) eval <= 1'b1;
      end
      if (eval) begin
        eval   <= 1'b0;
        status <= hit;
        done   <= 1'b1;
        busy   <= 1'b0;
      end
    end
  end

  always_comb begin
    hit = '0;
    for (int px = 0; px < PIX; px++) begin
      for (int e = 0; e < NENT; e++) begin
        if (!ent_q[e][7] &&
            ((ent_q[e][3:0] & cmask_q) ==
             ({pb[3][px], pb[2][px], pb[1][px], pb[0][px]} & cmask_q)))
          hit[px] = 1'b1;
      end
    end
  end

  AST_RD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> busy); // R3
  AST_RD_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_en && $past(mem_rd_en)) |-> ($stable(mem_rd_addr) && mem_rd_plane == $past(mem_rd_plane) + 2'd1)); // R3
  AST_NO_PLANE3_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_en && !has4_q) |-> (mem_rd_plane != 2'd3)); // R3
  AST_STATUS_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(status) |-> done); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_START_NEEDS_GO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(go)); // R2
  AST_BUSY_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> (busy || done)); // R9
endmodule

// File: tb/plane_color_match_bench.sv
module plane_color_match_bench;
  localparam int CLK_NS = 10;
  localparam int AW = 15;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ent_we = 1'b0;
  logic [2:0]    ent_idx = '0;
  logic [7:0]    ent_data = '0;
  logic [3:0]    plane_off = '0;
  logic          has_plane3 = 1'b1;
  logic          go = 1'b0;
  logic [7:0]    cmd = '0;
  logic [AW-1:0] addr = '0;
  logic          mem_rd_en;
  logic [1:0]    mem_rd_plane;
  logic [AW-1:0] mem_rd_addr;
  logic [7:0]    mem_rd_data = '0;
  logic          busy, done;
  logic [7:0]    status;

  logic [7:0] pl [4];
  int checks = 0, errors = 0, rd_cnt = 0, addr_bad = 0, order_bad = 0;
  int next_plane = 0;
  logic [AW-1:0] exp_addr = '0;
  bit finished = 0;

  always #(CLK_NS/2) clk = ~clk;

  plane_color_match u_plane_color_match (
    .clk(clk), .rst_n(rst_n), .ent_we(ent_we), .ent_idx(ent_idx), .ent_data(ent_data),
    .plane_off(plane_off), .has_plane3(has_plane3), .go(go), .cmd(cmd), .addr(addr),
    .mem_rd_en(mem_rd_en), .mem_rd_plane(mem_rd_plane), .mem_rd_addr(mem_rd_addr),
    .mem_rd_data(mem_rd_data), .busy(busy), .done(done), .status(status));

  always @(posedge clk) begin
    if (mem_rd_en) begin
      mem_rd_data <= pl[mem_rd_plane];
      rd_cnt++;
      if (mem_rd_addr != exp_addr) addr_bad++;
      if (int'(mem_rd_plane) != next_plane) order_bad++;
      next_plane = next_plane + 1;
    end
  end

  // {blue, red, green, plane3, plane_off, has_plane3, expected status}
  localparam logic [55:0] VEC [8] = '{
    {8'hF0, 8'h00, 8'h00, 8'h00, 8'h00, 8'h01, 8'hF0},
    {8'h00, 8'hAA, 8'hAA, 8'h00, 8'h00, 8'h01, 8'hAA},
    {8'hFF, 8'h00, 8'h00, 8'hFF, 8'h00, 8'h01, 8'h00},
    {8'h00, 8'h00, 8'h00, 8'hFF, 8'h00, 8'h01, 8'h00},
    {8'hFF, 8'h00, 8'h00, 8'hFF, 8'h00, 8'h00, 8'hFF},
    {8'h00, 8'h0F, 8'h0F, 8'h00, 8'h02, 8'h01, 8'h0F},
    {8'hFF, 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'hFF},
    {8'h80, 8'h01, 8'h01, 8'h00, 8'h00, 8'h01, 8'h81}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr_ent(input logic [2:0] i, input logic [7:0] d);
    @(negedge clk); ent_we = 1'b1; ent_idx = i; ent_data = d;
    @(negedge clk); ent_we = 1'b0;
  endtask

  task automatic run(input logic [7:0] c, output bit got_done);
    rd_cnt = 0; addr_bad = 0; order_bad = 0; next_plane = 0;
    @(negedge clk); go = 1'b1; cmd = c; exp_addr = addr;
    @(negedge clk); go = 1'b0;
    got_done = 0;
    for (int k = 0; k < 20 && !got_done; k++) begin
      if (done) got_done = 1;
      else @(negedge clk);
    end
  endtask

  initial begin
    #(CLK_NS * 100000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    bit d;
    logic [7:0] snap;
    for (int p = 0; p < 4; p++) pl[p] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 status after reset", status, 8'h00);
    addr = 15'h1234;
    run(8'h07, d);
    chk("R1 compare with reset entries done", d, 1);
    chk("R1 compare with reset entries", status, 8'h00);
    chk("R3 four reads", rd_cnt, 4);
    chk("R3 read address", addr_bad, 0);
    chk("R3 plane order", order_bad, 0);

    wr_ent(3'd0, 8'h01);
    wr_ent(3'd1, 8'h06);
    wr_ent(3'd2, 8'h88);

    foreach (VEC[v]) begin
      pl[0] = VEC[v][55:48]; pl[1] = VEC[v][47:40];
      pl[2] = VEC[v][39:32]; pl[3] = VEC[v][31:24];
      plane_off = VEC[v][19:16]; has_plane3 = VEC[v][8];
      addr = 15'(v * 37);
      run(8'h07, d);
      chk($sformatf("R4 R5 R6 R7 vector %0d", v), status, VEC[v][7:0]);
      chk($sformatf("R3 vector %0d read count", v), rd_cnt, has_plane3 ? 4 : 3);
      chk($sformatf("R3 vector %0d address", v), addr_bad, 0);
    end

    plane_off = 4'h0; has_plane3 = 1'b1;
    pl[0] = 8'hFF; pl[1] = 8'h00; pl[2] = 8'h00; pl[3] = 8'h00;
    snap = status;
    run(8'h01, d);
    chk("R2 op1 without bit6 no done", d, 0);
    chk("R2 op1 without bit6 no reads", rd_cnt, 0);
    chk("R2 status unchanged", status, snap);
    run(8'h41, d);
    chk("R2 op1 with bit6 runs", d, 1);
    chk("R2 op1 with bit6 result", status, 8'hFF);
    pl[0] = 8'h00;
    run(8'h47, d);
    chk("R2 op7 with bit6 runs", status, 8'h00);

    pl[0] = 8'h0F;
    rd_cnt = 0; addr_bad = 0; order_bad = 0; next_plane = 0;
    addr = 15'h0055; exp_addr = addr;
    @(negedge clk); go = 1'b1; cmd = 8'h07;
    @(negedge clk); addr = 15'h7777; snap = status;
    @(negedge clk); go = 1'b0;
    chk("R8 status held while busy", status, snap);
    chk("R8 busy during compare", busy, 1);
    d = 0;
    for (int k = 0; k < 20 && !d; k++) begin
      if (done) d = 1; else @(negedge clk);
    end
    chk("R8 new status with done", status, 8'h0F);
    @(negedge clk);
    chk("R8 done single cycle", done, 0);
    chk("R9 extra go made no reads", rd_cnt, 4);
    chk("R9 address of first go kept", addr_bad, 0);
    repeat (8) @(negedge clk);
    chk("R9 no second done", rd_cnt, 4);

    wr_ent(3'd7, 8'h0F);
    for (int p = 0; p < 4; p++) pl[p] = 8'hFF;
    addr = 15'h0001;
    run(8'h07, d);
    chk("R10 entry 7 written", status, 8'hFF);
    wr_ent(3'd7, 8'h8F);
    run(8'h07, d);
    chk("R5 R10 entry 7 disabled", status, 8'h00);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule